// File: doc/BRIEF.md
# Flat Request Aperture Router

This block takes one flat vector memory request per handshake and decides where it goes: on-chip shared local memory, a work-item's private scratch slot, or the global memory path. The decision looks at the first and the last byte the request touches. Each byte is placed in one of four regions: the shared aperture, the private aperture, the non-canonical hole, or the default space. If both ends fall in the same aperture, the address is rewritten for that target. If they fall in different regions, or the request lies in the hole, the request goes to no target and comes back as a memory violation for trap reporting.

Pointer interpretation depends on two configuration bits. One bit selects the default translation space. The other asks for 32-bit pointers, and it only takes effect when the default space bit is set. In 32-bit mode each aperture is a single 64 KB page, and a page number of zero turns it off. In the 64-bit modes each aperture spans an inclusive range of 64 KB pages. Results are registered in a single output stage that holds its value until the consumer accepts it.

Top module: `flat_aperture_router`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: 32-bit pointer mode is active only when `dflt_xlat`=1 and `ptr32_en`=1. When `dflt_xlat`=0, `ptr32_en` has no effect and all 64 address bits are used.
- R3: In 64-bit mode a byte hits an aperture when address bits [63:16] lie between that aperture's base page and limit page, both ends inclusive. If the two apertures overlap, shared wins over private.
- R4: In 32-bit mode address bits [63:32] are ignored. An aperture covers exactly the one 64 KB page whose number is given by bits [31:16] of its base page, and it is disabled when that number is zero. The limit pages are ignored.
- R5: A request wholly inside the shared aperture leaves with `out_tgt`=1, `out_xlat`=0 and `out_addr` = zero-extended low 16 bits of (address − shared base).
- R6: A request wholly inside the private aperture leaves with `out_tgt`=2, `out_addr` = hidden_base + tid × item_size + (address − private base), and `out_xlat` = `hidden_xlat`.
- R7: A request wholly in the default space leaves with `out_tgt`=0, `out_addr` = the address as interpreted (zero-extended in 32-bit mode) and `out_xlat` = `dflt_xlat`.
- R8: Size code c covers 2^min(c,4) bytes, so codes 5 to 7 mean 16 bytes. The last byte is the start + bytes − 1, wrapping modulo 2^32 in 32-bit mode and modulo 2^64 otherwise.
- R9: When the first and last bytes fall in different regions, the result has `out_viol`=1, `out_tgt`=3, `out_xlat`=0 and `out_addr` = the interpreted start address.
- R10: In 64-bit mode a byte whose bits [63:47] are neither all zeros nor all ones, and which hits no aperture, is in the hole. A request touching the hole is reported as in R9. 32-bit mode has no hole.
- R11: `in_ready` = !`out_valid` | `out_ready`. An accepted request appears on the outputs one cycle later. The outputs stay stable while `out_valid`=1 and `out_ready`=0, and the slot empties after acceptance when no new request comes in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_addr | input | 64 | Flat pointer |
| in_size | input | 3 | Payload size code |
| in_tid | input | 6 | Work-item id |
| dflt_xlat | input | 1 | Default translation space bit |
| ptr32_en | input | 1 | 32-bit pointer request |
| shared_base | input | 48 | Shared aperture first 64 KB page |
| shared_limit | input | 48 | Shared aperture last 64 KB page |
| private_base | input | 48 | Private aperture first 64 KB page |
| private_limit | input | 48 | Private aperture last 64 KB page |
| hidden_base | input | 64 | Start of hidden private backing region |
| hidden_xlat | input | 1 | Translation space of hidden private region |
| item_size | input | 20 | Private bytes per work-item |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_tgt | output | 2 | 0 global, 1 shared, 2 private, 3 none |
| out_addr | output | 64 | Rewritten address |
| out_xlat | output | 1 | Translation space for the rewritten address |
| out_viol | output | 1 | Memory violation |

## Verification
Random requests are placed around every region edge: both ends of each aperture, the two borders of the hole, the 32-bit wrap point and the pages next to the 32-bit apertures. Offsets of up to 32 bytes on either side, together with all size codes, make the first and last bytes land in the same region or in different ones. The upper word is sometimes filled with noise so that 32-bit mode can be told apart from 64-bit mode. Directed cases cover exact inclusive limits, the canonical-to-hole wrap, clamping of size codes 5 to 7, overlapping apertures, disabling a zero page, `ptr32_en` being ignored, and holding the output under backpressure.

// File: rtl/flat_route_pkg.sv
package flat_route_pkg;

    typedef enum logic [1:0] {
        RGN_DEFAULT = 2'd0,
        RGN_SHARED  = 2'd1,
        RGN_PRIVATE = 2'd2,
        RGN_HOLE    = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        TGT_GLOBAL  = 2'd0,
        TGT_SHARED  = 2'd1,
        TGT_PRIVATE = 2'd2,
        TGT_NONE    = 2'd3
    } target_e;

endpackage

// File: rtl/flat_region_classify.sv
module flat_region_classify
    import flat_route_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int APE_LSB = 16,
    parameter int VA_TOP  = 47,
    parameter int PG_W    = ADDR_W - APE_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode32,
    input  logic [PG_W-1:0]   sh_lo,
    input  logic [PG_W-1:0]   sh_hi,
    input  logic              sh_en,
    input  logic [PG_W-1:0]   pv_lo,
    input  logic [PG_W-1:0]   pv_hi,
    input  logic              pv_en,
    output region_e           region
);
    localparam int TOP_W = ADDR_W - VA_TOP;

    logic [PG_W-1:0]  page;
    logic [TOP_W-1:0] top_bits;
    logic             hit_sh;
    logic             hit_pv;
    logic             canonical;

    always_comb begin
        page      = addr[ADDR_W-1:APE_LSB];
        top_bits  = addr[ADDR_W-1:VA_TOP];
        hit_sh    = sh_en && (page >= sh_lo) && (page <= sh_hi);
        hit_pv    = pv_en && (page >= pv_lo) && (page <= pv_hi);
        canonical = mode32 || (&top_bits) || (~|top_bits);
        if (hit_sh)          region = RGN_SHARED;
        else if (hit_pv)     region = RGN_PRIVATE;
        else if (!canonical) region = RGN_HOLE;
        else                 region = RGN_DEFAULT;
    end

endmodule

// File: rtl/flat_addr_rewrite.sv
module flat_addr_rewrite
    import flat_route_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int TID_W    = 6,
    parameter int ITEM_W   = 20,
    parameter int LOCAL_AW = 16
) (
    input  region_e           first_rgn,
    input  region_e           last_rgn,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [ADDR_W-1:0] sh_base_addr,
    input  logic [ADDR_W-1:0] pv_base_addr,
    input  logic [ADDR_W-1:0] hidden_base,
    input  logic              hidden_xlat,
    input  logic [ITEM_W-1:0] item_size,
    input  logic [TID_W-1:0]  tid,
    input  logic              dflt_xlat,
    output target_e           tgt,
    output logic [ADDR_W-1:0] addr,
    output logic              xlat,
    output logic              viol
);
    logic [LOCAL_AW-1:0] local_ofs;
    logic [ADDR_W-1:0]   slot_ofs;
    logic [ADDR_W-1:0]   priv_ofs;

    always_comb begin
        local_ofs = LOCAL_AW'(eff_addr - sh_base_addr);
        slot_ofs  = ADDR_W'(tid) * ADDR_W'(item_size);
        priv_ofs  = eff_addr - pv_base_addr;
        viol      = (first_rgn != last_rgn) || (first_rgn == RGN_HOLE);

        tgt  = TGT_NONE;
        addr = eff_addr;
        xlat = 1'b0;
        if (!viol) begin
            unique case (first_rgn)
                RGN_SHARED: begin
                    tgt  = TGT_SHARED;
                    addr = ADDR_W'(local_ofs);
                end
                RGN_PRIVATE: begin
                    tgt  = TGT_PRIVATE;
                    addr = hidden_base + slot_ofs + priv_ofs;
                    xlat = hidden_xlat;
                end
                default: begin
                    tgt  = TGT_GLOBAL;
                    xlat = dflt_xlat;
                end
            endcase
        end
    end

endmodule

// File: rtl/flat_aperture_router.sv
module flat_aperture_router
    import flat_route_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int APE_LSB   = 16,
    parameter int VA_TOP    = 47,
    parameter int P32_W     = 32,
    parameter int TID_W     = 6,
    parameter int ITEM_W    = 20,
    parameter int SIZE_W    = 3,
    parameter int MAX_SCODE = 4,
    parameter int LOCAL_AW  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [ADDR_W-1:0]         in_addr,
    input  logic [SIZE_W-1:0]         in_size,
    input  logic [TID_W-1:0]          in_tid,
    input  logic                      dflt_xlat,
    input  logic                      ptr32_en,
    input  logic [ADDR_W-1:APE_LSB]   shared_base,
    input  logic [ADDR_W-1:APE_LSB]   shared_limit,
    input  logic [ADDR_W-1:APE_LSB]   private_base,
    input  logic [ADDR_W-1:APE_LSB]   private_limit,
    input  logic [ADDR_W-1:0]         hidden_base,
    input  logic                      hidden_xlat,
    input  logic [ITEM_W-1:0]         item_size,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [1:0]                out_tgt,
    output logic [ADDR_W-1:0]         out_addr,
    output logic                      out_xlat,
    output logic                      out_viol
);
    localparam int PG_W = ADDR_W - APE_LSB;
    localparam int NPROBE = 2;

    typedef struct packed {
        logic              valid;
        target_e           tgt;
        logic [ADDR_W-1:0] addr;
        logic              xlat;
        logic              viol;
    } slot_t;

    slot_t st_d, st_q;

    logic              mode32;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] last_addr;
    logic [SIZE_W-1:0] size_cl;
    logic [ADDR_W-1:0] span;
    logic [PG_W-1:0]   sh_lo, sh_hi, pv_lo, pv_hi;
    logic              sh_en, pv_en;
    logic [ADDR_W-1:0] probe [NPROBE];
    region_e           rgn   [NPROBE];

    target_e           rw_tgt;
    logic [ADDR_W-1:0] rw_addr;
    logic              rw_xlat;
    logic              rw_viol;

    // Pointer interpretation and aperture bounds for the active mode
    always_comb begin
        mode32   = dflt_xlat & ptr32_en;
        eff_addr = mode32 ? ADDR_W'(in_addr[P32_W-1:0]) : in_addr;
        size_cl  = (in_size > SIZE_W'(MAX_SCODE)) ? SIZE_W'(MAX_SCODE) : in_size;
        span     = (ADDR_W'(1) << size_cl) - ADDR_W'(1);
        last_addr = eff_addr + span;
        if (mode32) last_addr = ADDR_W'(last_addr[P32_W-1:0]);

        if (mode32) begin
            sh_lo = PG_W'(shared_base[P32_W-1:APE_LSB]);
            sh_hi = sh_lo;
            sh_en = |shared_base[P32_W-1:APE_LSB];
            pv_lo = PG_W'(private_base[P32_W-1:APE_LSB]);
            pv_hi = pv_lo;
            pv_en = |private_base[P32_W-1:APE_LSB];
        end else begin
            sh_lo = shared_base;
            sh_hi = shared_limit;
            sh_en = 1'b1;
            pv_lo = private_base;
            pv_hi = private_limit;
            pv_en = 1'b1;
        end
        probe[0] = eff_addr;
        probe[1] = last_addr;
    end

    for (genvar g = 0; g < NPROBE; g++) begin : g_probe
        flat_region_classify #(
            .ADDR_W (ADDR_W),
            .APE_LSB(APE_LSB),
            .VA_TOP (VA_TOP)
        ) i_classify (
            .addr  (probe[g]),
            .mode32(mode32),
            .sh_lo (sh_lo),
            .sh_hi (sh_hi),
            .sh_en (sh_en),
            .pv_lo (pv_lo),
            .pv_hi (pv_hi),
            .pv_en (pv_en),
            .region(rgn[g])
        );
    end

    flat_addr_rewrite #(
        .ADDR_W  (ADDR_W),
        .TID_W   (TID_W),
        .ITEM_W  (ITEM_W),
        .LOCAL_AW(LOCAL_AW)
    ) i_rewrite (
        .first_rgn   (rgn[0]),
        .last_rgn    (rgn[NPROBE-1]),
        .eff_addr    (eff_addr),
        .sh_base_addr({sh_lo, {APE_LSB{1'b0}}}),
        .pv_base_addr({pv_lo, {APE_LSB{1'b0}}}),
        .hidden_base (hidden_base),
        .hidden_xlat (hidden_xlat),
        .item_size   (item_size),
        .tid         (in_tid),
        .dflt_xlat   (dflt_xlat),
        .tgt         (rw_tgt),
        .addr        (rw_addr),
        .xlat        (rw_xlat),
        .viol        (rw_viol)
    );

    // Next-state for the output slot
    always_comb begin
        in_ready = !st_q.valid || out_ready;
        st_d     = st_q;
        if (in_ready) begin
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.tgt  = rw_tgt;
                st_d.addr = rw_addr;
                st_d.xlat = rw_xlat;
                st_d.viol = rw_viol;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, tgt: TGT_GLOBAL, addr: '0, xlat: 1'b0, viol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_tgt   = st_q.tgt;
    assign out_addr  = st_q.addr;
    assign out_xlat  = st_q.xlat;
    assign out_viol  = st_q.viol;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tgt) && $stable(out_addr)
                                    && $stable(out_xlat) && $stable(out_viol)); // R11

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R11

    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid); // R11

    AST_VIOL_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_viol == (out_tgt == TGT_NONE))); // R9

    AST_LOCAL_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_tgt == TGT_SHARED |-> out_addr[ADDR_W-1:LOCAL_AW] == '0 && !out_xlat); // R5

endmodule

// File: tb/test_flat_aperture_router.sv
`timescale 1ns/1ps
module test_flat_aperture_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_addr = '0;
    logic [2:0]  in_size = '0;
    logic [5:0]  in_tid = '0;
    logic        dflt_xlat = 1'b0;
    logic        ptr32_en = 1'b0;
    logic [63:16] shared_base = '0, shared_limit = '0, private_base = '0, private_limit = '0;
    logic [63:0] hidden_base = '0;
    logic        hidden_xlat = 1'b0;
    logic [19:0] item_size = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_tgt;
    logic [63:0] out_addr;
    logic        out_xlat;
    logic        out_viol;

    int checks = 0;
    int errors = 0;

    logic [1:0]  e_tgt;
    logic [63:0] e_addr;
    logic        e_xlat;
    logic        e_viol;

    always #2.5 clk = ~clk;

    flat_aperture_router i_flat_aperture_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_size(in_size), .in_tid(in_tid),
        .dflt_xlat(dflt_xlat), .ptr32_en(ptr32_en),
        .shared_base(shared_base), .shared_limit(shared_limit),
        .private_base(private_base), .private_limit(private_limit),
        .hidden_base(hidden_base), .hidden_xlat(hidden_xlat), .item_size(item_size),
        .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt),
        .out_addr(out_addr), .out_xlat(out_xlat), .out_viol(out_viol)
    );

    // 0 default, 1 shared, 2 private, 3 hole
    function automatic logic [1:0] region_of(input logic [63:0] a, input logic m32);
        logic [1:0] r;
        r = 2'd0;
        if (m32) begin
            if (shared_base[31:16] != 0 && a[31:16] == shared_base[31:16]) r = 2'd1;
            else if (private_base[31:16] != 0 && a[31:16] == private_base[31:16]) r = 2'd2;
        end else begin
            if (a[63:16] >= shared_base && a[63:16] <= shared_limit) r = 2'd1;
            else if (a[63:16] >= private_base && a[63:16] <= private_limit) r = 2'd2;
            else if (a[63:47] != 17'h0 && a[63:47] != 17'h1FFFF) r = 2'd3;
        end
        return r;
    endfunction

    task automatic predict(input logic [63:0] a, input logic [2:0] sz, input logic [5:0] tid,
                           output string tag);
        logic        m32;
        logic [63:0] ea, la, nbytes, pbase, sbase;
        logic [1:0]  rf, rl;
        m32    = dflt_xlat && ptr32_en;
        ea     = m32 ? {32'h0, a[31:0]} : a;
        nbytes = 64'd1 << ((sz > 3'd4) ? 3'd4 : sz);
        la     = ea + nbytes - 64'd1;
        if (m32) la[63:32] = 32'h0;
        rf = region_of(ea, m32);
        rl = region_of(la, m32);
        sbase = m32 ? {32'h0, shared_base[31:16], 16'h0} : {shared_base, 16'h0};
        pbase = m32 ? {32'h0, private_base[31:16], 16'h0} : {private_base, 16'h0};
        if (rf != rl || rf == 2'd3) begin
            e_tgt = 2'd3; e_addr = ea; e_xlat = 1'b0; e_viol = 1'b1;
            tag = (rf == 2'd3 || rl == 2'd3) ? "R10" : "R9";
        end else if (rf == 2'd1) begin
            e_tgt = 2'd1; e_addr = {48'h0, ea[15:0] - sbase[15:0]}; e_xlat = 1'b0; e_viol = 1'b0;
            tag = "R5";
        end else if (rf == 2'd2) begin
            e_tgt = 2'd2; e_addr = hidden_base + 64'(tid) * 64'(item_size) + (ea - pbase);
            e_xlat = hidden_xlat; e_viol = 1'b0;
            tag = "R6";
        end else begin
            e_tgt = 2'd0; e_addr = ea; e_xlat = dflt_xlat; e_viol = 1'b0;
            tag = "R7";
        end
    endtask

    task automatic check_out(input string tag);
        checks++;
        if (!(out_valid === 1'b1 && out_tgt === e_tgt && out_addr === e_addr &&
              out_xlat === e_xlat && out_viol === e_viol)) begin
            errors++;
            $display("FAIL %s: got v=%0b tgt=%0d addr=%h x=%0b viol=%0b exp v=1 tgt=%0d addr=%h x=%0b viol=%0b",
                     tag, out_valid, out_tgt, out_addr, out_xlat, out_viol, e_tgt, e_addr, e_xlat, e_viol);
        end
    endtask

    // One request through the slot; tag "" uses the predicted class
    task automatic xfer(input logic [63:0] a, input logic [2:0] sz, input logic [5:0] tid,
                        input string tag, input bit hold);
        string ptag;
        @(negedge clk);
        in_addr = a; in_size = sz; in_tid = tid; in_valid = 1'b1; out_ready = 1'b0;
        predict(a, sz, tid, ptag);
        @(negedge clk);
        in_valid = 1'b0;
        check_out(tag == "" ? ptag : tag);
        if (hold) begin
            repeat (2) @(negedge clk);
            check_out("R11 hold");
            checks++;
            if (in_ready !== 1'b0) begin
                errors++;
                $display("FAIL R11: in_ready=%0b while full and stalled, exp 0", in_ready);
            end
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        if (hold) begin
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R11: out_valid=%0b after drain, exp 0", out_valid);
            end
        end
    endtask

    task automatic set64(input logic atc, input logic p32);
        dflt_xlat = atc; ptr32_en = p32;
        shared_base   = 48'h1000_0000_0000;
        shared_limit  = 48'h1000_0000_FFFF;
        private_base  = 48'h1000_0001_0000;
        private_limit = 48'h1000_0001_FFFF;
        hidden_base   = 64'h0000_7F00_0000_0000;
        hidden_xlat   = 1'b0;
        item_size     = 20'h400;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_0042));
        set64(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1: out_valid=%0b in_ready=%0b exp 0/1", out_valid, in_ready);
        end
        rst_n = 1'b1;

        // 64-bit directed
        set64(1'b1, 1'b0);
        xfer(64'h1000_0000_0000_0000, 3'd4, 6'd0, "R5 shared start", 1'b1);
        xfer(64'h1000_0000_FFFF_FFF0, 3'd4, 6'd0, "R3 shared limit inclusive", 1'b0);
        xfer(64'h1000_0000_FFFF_FFF1, 3'd4, 6'd0, "R9 shared to private", 1'b1);
        xfer(64'h1000_0001_0000_0010, 3'd2, 6'd5, "R6 private tid5", 1'b0);
        xfer(64'h0000_8000_0000_0000, 3'd0, 6'd0, "R10 hole", 1'b0);
        xfer(64'h0000_7FFF_FFFF_FFF8, 3'd4, 6'd0, "R8 wrap into hole", 1'b0);
        xfer(64'h0000_0000_0000_1000, 3'd3, 6'd0, "R7 global hsa64", 1'b0);
        xfer(64'h1000_0000_FFFF_FFF8, 3'd7, 6'd0, "R8 code7 is 16B", 1'b0);
        xfer(64'h1000_0000_FFFF_FFF8, 3'd3, 6'd0, "R8 code3 is 8B", 1'b0);
        set64(1'b0, 1'b1);
        xfer(64'hFFFF_8000_0000_1000, 3'd1, 6'd0, "R2 ptr32 ignored", 1'b0);
        private_base = 48'h1000_0000_0000;
        xfer(64'h1000_0000_0000_0040, 3'd0, 6'd3, "R3 overlap shared wins", 1'b0);

        // 32-bit directed
        set64(1'b1, 1'b1);
        shared_base  = 48'h1000_0000_0003;
        private_base = 48'h1000_0000_0005;
        shared_limit = 48'h1000_0000_0009;
        xfer(64'hDEAD_BEEF_0003_0010, 3'd2, 6'd0, "R4 upper ignored shared", 1'b0);
        xfer(64'h0000_0000_0004_0000, 3'd0, 6'd0, "R4 limit ignored", 1'b0);
        xfer(64'h0000_0000_0003_FFFC, 3'd3, 6'd0, "R9 32b straddle", 1'b0);
        xfer(64'h0000_0000_0005_0100, 3'd4, 6'd9, "R6 32b private", 1'b0);
        xfer(64'h0000_0000_8000_0000, 3'd4, 6'd0, "R10 no hole in 32b", 1'b0);
        xfer(64'h0000_0000_FFFF_FFFC, 3'd3, 6'd0, "R8 32b wrap", 1'b0);
        shared_base = 48'h1000_0000_0000;
        xfer(64'h0000_0000_0000_0010, 3'd0, 6'd0, "R4 zero page disabled", 1'b0);

        // constrained random
        for (int n = 0; n < 1500; n++) begin
            logic [63:0] anchor, a;
            int sel;
            sel = $urandom % 3;
            set64(sel != 2, sel == 0 || ($urandom % 4 == 0));
            shared_base[31:16]  = ($urandom % 8 == 0) ? 16'h0 : 16'h0003;
            private_base[31:16] = ($urandom % 8 == 0) ? 16'h0 : 16'h0005;
            hidden_xlat = 1'($urandom);
            item_size   = 20'($urandom);
            case ($urandom % 12)
                0: anchor = {shared_base, 16'h0};
                1: anchor = {shared_limit, 16'hFFFF} + 64'd1;
                2: anchor = {private_base, 16'h0};
                3: anchor = {private_limit, 16'hFFFF} + 64'd1;
                4: anchor = 64'h0;
                5: anchor = 64'h0000_8000_0000_0000;
                6: anchor = 64'hFFFF_8000_0000_0000;
                7: anchor = {32'h0, 16'h0003, 16'h0};
                8: anchor = {32'h0, 16'h0004, 16'h0};
                9: anchor = {32'h0, 16'h0005, 16'h0};
                10: anchor = 64'h0000_0001_0000_0000;
                default: anchor = {$urandom, $urandom};
            endcase
            a = anchor + 64'($urandom % 64) - 64'd32;
            if ($urandom % 4 == 0) a[63:32] = $urandom;
            xfer(a, 3'($urandom % 8), 6'($urandom), "", ($urandom % 16) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule